// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate-Long Unit

This unit decodes and executes one kind of instruction: a signed 16×16 multiply whose 32-bit product is added to a 64-bit accumulator. It reads a 32-bit instruction word in one of two bit layouts. The `mode_cond` input chooses the layout: a compact layout, or a conditional layout that carries a 4-bit condition field. The unit checks the fixed opcode bits of the chosen layout. It pulls out the two source register indices, the two destination register indices and the two half-select bits.

The caller uses the combinational `rn_idx`/`rm_idx` outputs to fetch operands. It then supplies the two source operand values and the current high and low accumulator words, and pulses `in_valid` once. One clock later the unit returns one of two responses:
- For an accepted instruction, a one-cycle `res_valid` write-enable with the new high and low words and the destination indices.
- For a word whose fixed bits are wrong, a one-cycle `illegal` pulse.

Condition evaluation is done outside the unit. It arrives as `cond_pass`.

Top module: `hw_mac_long`

## Requirements
- R1: The Rn operand contributes bits [15:0] when its select bit N is 0 and bits [31:16] when N is 1. The Rm operand likewise uses select bit M. The unselected half of each operand has no effect on the result.
- R2: The two selected halves are multiplied as signed 16-bit numbers. The 32-bit signed product is sign-extended to 64 bits.
- R3: The result {res_hi, res_lo} is {acc_hi, acc_lo} plus the extended product, taken modulo 2^64. Overflow wraps silently and raises no flag.
- R4: In the compact layout (`mode_cond`=0), bits [31:20] must be 12'hFBC and bits [7:6] must be 2'b10. The fields are: Rn=[19:16], low destination=[15:12], high destination=[11:8], N=bit 5, M=bit 4, Rm=[3:0].
- R5: In the conditional layout (`mode_cond`=1), bits [27:20] must be 8'h14, bit 7 must be 1 and bit 4 must be 0. The fields are: condition=[31:28], high destination=[19:16], low destination=[15:12], Rm=[11:8], M=bit 6, N=bit 5, Rn=[3:0].
- R6: A strobed word whose fixed bits do not match the selected layout gives `illegal`=1 for exactly the next cycle and no write (`res_valid`=0). The result registers are left unchanged.
- R7: In the conditional layout, a condition field of 4'b1111 never executes. Such a legal word gives neither `res_valid` nor `illegal`, and the result registers are unchanged.
- R8: A legal word strobed with `cond_pass`=0, in either layout, gives no write and no `illegal`. The result registers are unchanged.
- R9: A strobe accepted for execution at clock edge k gives `res_valid`=1 for exactly the cycle after edge k. At that point `res_hi`, `res_lo`, `wb_hi_idx` and `wb_lo_idx` hold its values. Without such a strobe `res_valid` is 0 and these outputs hold their previous values.
- R10: Synchronous active-high `rst` clears `res_valid`, `illegal`, both result words and both write-back indices to zero.
- R11: `rn_idx` and `rm_idx` follow `instr` and `mode_cond` combinationally, using the field positions of R4 and R5. No clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| mode_cond | input | 1 | 0 = compact layout, 1 = conditional layout |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Result of the external condition check |
| rn_val | input | 32 | Value of the register named by rn_idx |
| rm_val | input | 32 | Value of the register named by rm_idx |
| acc_hi | input | 32 | Current high accumulator word |
| acc_lo | input | 32 | Current low accumulator word |
| rn_idx | output | 4 | Decoded Rn index (combinational) |
| rm_idx | output | 4 | Decoded Rm index (combinational) |
| res_valid | output | 1 | Write enable pulse for the result |
| illegal | output | 1 | Fixed-bit mismatch pulse |
| wb_hi_idx | output | 4 | Destination index for res_hi |
| wb_lo_idx | output | 4 | Destination index for res_lo |
| res_hi | output | 32 | Upper 32 bits of the new accumulator |
| res_lo | output | 32 | Lower 32 bits of the new accumulator |

## Verification
The assertions check four rules on every cycle:
- `res_valid` and `illegal` never coincide, and neither rises without a strobe one cycle earlier.
- A strobe with `cond_pass` low never writes.
- When no write occurs, the result words stay stable.
- Every write equals the previous cycle's accumulator plus an independently computed product of the selected halves.

Only the bench's scenarios can show the rest. That covers the correct field positions in each layout and the exact handling of the 16'h8000 and 16'h7FFF extremes. It also covers the modulo-2^64 wrap near 2^63 and 2^64, and that an illegal or 4'b1111 word leaves the previous result untouched.

// File: rtl/hw_mac_long.sv
module hw_mac_long #(
  parameter int unsigned XW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          mode_cond,
  input  logic [31:0]   instr,
  input  logic          cond_pass,
  input  logic [XW-1:0] rn_val,
  input  logic [XW-1:0] rm_val,
  input  logic [XW-1:0] acc_hi,
  input  logic [XW-1:0] acc_lo,
  output logic [IW-1:0] rn_idx,
  output logic [IW-1:0] rm_idx,
  output logic          res_valid,
  output logic          illegal,
  output logic [IW-1:0] wb_hi_idx,
  output logic [IW-1:0] wb_lo_idx,
  output logic [XW-1:0] res_hi,
  output logic [XW-1:0] res_lo
);
  localparam int unsigned HW = XW / 2;
  localparam int unsigned AW = 2 * XW;

  logic fix_compact, fix_cond, legal, never_cc, execute;
  logic sel_n, sel_m;
  logic [IW-1:0] dhi, dlo;
  logic signed [HW-1:0] half_n, half_m;
  logic signed [XW-1:0] prod;
  logic [AW-1:0] prod_ext, sum;

  assign fix_compact = (instr[31:20] == 12'hFBC) && (instr[7:6] == 2'b10);
  assign fix_cond    = (instr[27:20] == 8'h14) && instr[7] && !instr[4];
  assign legal       = mode_cond ? fix_cond : fix_compact;
  assign never_cc    = mode_cond && (instr[31:28] == 4'hF);
  assign execute     = in_valid && legal && cond_pass && !never_cc;

  assign rn_idx = mode_cond ? instr[3:0]   : instr[19:16];
  assign rm_idx = mode_cond ? instr[11:8]  : instr[3:0];
  assign dhi    = mode_cond ? instr[19:16] : instr[11:8];
  assign dlo    = instr[15:12];
  assign sel_n  = instr[5];
  assign sel_m  = mode_cond ? instr[6] : instr[4];

  assign half_n   = sel_n ? rn_val[XW-1:HW] : rn_val[HW-1:0];
  assign half_m   = sel_m ? rm_val[XW-1:HW] : rm_val[HW-1:0];
  assign prod     = half_n * half_m;
  assign prod_ext = {{(AW-XW){prod[XW-1]}}, prod};
  assign sum      = {acc_hi, acc_lo} + prod_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      wb_hi_idx <= '0;
      wb_lo_idx <= '0;
      res_hi    <= '0;
      res_lo    <= '0;
    end else begin
      res_valid <= execute;
      illegal   <= in_valid && !legal;
      if (execute) begin
        wb_hi_idx <= dhi;
        wb_lo_idx <= dlo;
        res_hi    <= sum[AW-1:XW];
        res_lo    <= sum[XW-1:0];
      end
    end
  end
endmodule

module hw_mac_long_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        mode_cond,
  input logic [31:0] instr,
  input logic        cond_pass,
  input logic [31:0] rn_val,
  input logic [31:0] rm_val,
  input logic [31:0] acc_hi,
  input logic [31:0] acc_lo,
  input logic        res_valid,
  input logic        illegal,
  input logic [31:0] res_hi,
  input logic [31:0] res_lo
);
  logic signed [15:0] cn, cm;
  logic signed [31:0] cp;
  logic [63:0] c_expect;
  always_comb begin
    cn = instr[5] ? rn_val[31:16] : rn_val[15:0];
    if (mode_cond) cm = instr[6] ? rm_val[31:16] : rm_val[15:0];
    else           cm = instr[4] ? rm_val[31:16] : rm_val[15:0];
    cp = cn * cm;
    c_expect = {acc_hi, acc_lo} + {{32{cp[31]}}, cp};
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && illegal));
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));
  a_r6_illegal_after_strobe: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(in_valid));
  a_r8_no_write_on_fail: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !cond_pass) |-> !res_valid);
  a_r3_wrapped_sum: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ({res_hi, res_lo} == $past(c_expect)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !$past(rst)) |-> $stable({res_hi, res_lo}));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && !illegal));
endmodule

bind hw_mac_long hw_mac_long_chk u_chk (.*);

// File: tb/hw_mac_long_tb.sv
module hw_mac_long_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, mode_cond = 1'b0, cond_pass = 1'b1;
  logic [31:0] instr = '0, rn_val = '0, rm_val = '0, acc_hi = '0, acc_lo = '0;
  logic [3:0] rn_idx, rm_idx, wb_hi_idx, wb_lo_idx;
  logic res_valid, illegal;
  logic [31:0] res_hi, res_lo;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_mac_long u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_cond(mode_cond), .instr(instr),
    .cond_pass(cond_pass), .rn_val(rn_val), .rm_val(rm_val), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .rn_idx(rn_idx), .rm_idx(rm_idx), .res_valid(res_valid), .illegal(illegal),
    .wb_hi_idx(wb_hi_idx), .wb_lo_idx(wb_lo_idx), .res_hi(res_hi), .res_lo(res_lo));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] enc_c(input logic [3:0] rn, dlo, dhi, input logic n, m, input logic [3:0] rm);
    return {12'hFBC, rn, dlo, dhi, 2'b10, n, m, rm};
  endfunction
  function automatic logic [31:0] enc_a(input logic [3:0] cc, dhi, dlo, rm, input logic m, n, input logic [3:0] rn);
    return {cc, 8'h14, dhi, dlo, rm, 1'b1, m, n, 1'b0, rn};
  endfunction
  function automatic logic [63:0] ref_mac(input logic [15:0] a, b, input logic [63:0] acc);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return acc + {{32{p[31]}}, p};
  endfunction
  function automatic logic [15:0] pick(input int k);
    case (k % 6)
      0: return 16'h8000; 1: return 16'h7FFF; 2: return 16'h0000;
      3: return 16'h0001; 4: return 16'hFFFF; default: return 16'h1234;
    endcase
  endfunction
  function automatic logic [63:0] pick_acc(input int k);
    case (k)
      0: return 64'h7FFF_FFFF_FFFF_FFF0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_0000_0000;
    endcase
  endfunction

  task automatic strobe(input logic md, input logic [31:0] w, input logic cp,
                        input logic [31:0] a, b, input logic [63:0] acc);
    mode_cond = md; instr = w; cond_pass = cp; rn_val = a; rm_val = b;
    {acc_hi, acc_lo} = acc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk("R10 valid/illegal in reset", {62'd0, res_valid, illegal}, 64'd0);
    chk("R10 result in reset", {res_hi, res_lo}, 64'd0);
    chk("R10 indices in reset", {56'd0, wb_hi_idx, wb_lo_idx}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R11: combinational index decode in each layout
    mode_cond = 1'b0; instr = enc_c(4'd7, 4'd1, 4'd2, 1'b0, 1'b0, 4'd9); #1;
    chk("R11 compact rn/rm", {56'd0, rn_idx, rm_idx}, {56'd0, 4'd7, 4'd9});
    mode_cond = 1'b1; instr = enc_a(4'hE, 4'd2, 4'd1, 4'd9, 1'b0, 1'b0, 4'd7); #1;
    chk("R11 conditional rn/rm", {56'd0, rn_idx, rm_idx}, {56'd0, 4'd7, 4'd9});
    @(negedge clk);

    // R1 R2 R3 R4 R5 R9: sweep of layouts, variants, extreme operands, accumulators
    for (int md = 0; md < 2; md++)
      for (int nm = 0; nm < 4; nm++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            for (int k = 0; k < 3; k++) begin
              logic n, m;
              logic [31:0] a, b, w;
              logic [3:0] dh, dl;
              n = nm[1]; m = nm[0];
              a = n ? {pick(i), pick(i+3)} : {pick(i+3), pick(i)};
              b = m ? {pick(j), pick(j+2)} : {pick(j+2), pick(j)};
              dh = 4'(i + j + k); dl = 4'(15 - i - k);
              w = md[0] ? enc_a(4'(k), dh, dl, 4'(j), m, n, 4'(i))
                        : enc_c(4'(i), dl, dh, n, m, 4'(j));
              strobe(md[0], w, 1'b1, a, b, pick_acc(k));
              chk("R9 valid pulse", {62'd0, res_valid, illegal}, 64'd2);
              chk(md[0] ? "R5 R1 R2 R3 result" : "R4 R1 R2 R3 result",
                  {res_hi, res_lo}, ref_mac(pick(i), pick(j), pick_acc(k)));
              chk(md[0] ? "R5 write indices" : "R4 write indices",
                  {56'd0, wb_hi_idx, wb_lo_idx}, {56'd0, dh, dl});
              @(negedge clk);
              chk("R9 valid single cycle", {63'd0, res_valid}, 64'd0);
            end

    // R3: explicit wrap past 2^64 and signed extreme
    strobe(1'b0, enc_c(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 4'd4), 1'b1, 32'h0000_8000, 32'h0000_8000, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 wrap modulo 2^64", {res_hi, res_lo}, 64'h0000_0000_3FFF_FFFF);
    strobe(1'b1, enc_a(4'h0, 4'd3, 4'd2, 4'd4, 1'b1, 1'b1, 4'd1), 1'b1, 32'h7FFF_0000, 32'h8000_FFFF, 64'd0);
    chk("R2 7FFF x 8000 top/top", {res_hi, res_lo}, 64'hFFFF_FFFF_C000_8000);
    held = {res_hi, res_lo};

    // R6: fixed-bit mismatch in each layout
    strobe(1'b0, enc_c(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 4'd4) ^ 32'h0000_0040, 1'b1, 32'h1, 32'h1, 64'd5);
    chk("R6 compact illegal pulse", {62'd0, res_valid, illegal}, 64'd1);
    chk("R6 compact result unchanged", {res_hi, res_lo}, held);
    strobe(1'b1, enc_a(4'h0, 4'd3, 4'd2, 4'd4, 1'b0, 1'b0, 4'd1) | 32'h0000_0010, 1'b1, 32'h1, 32'h1, 64'd5);
    chk("R6 conditional illegal pulse", {62'd0, res_valid, illegal}, 64'd1);
    strobe(1'b1, enc_c(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 4'd4), 1'b1, 32'h1, 32'h1, 64'd5);
    chk("R6 compact word in conditional mode", {62'd0, res_valid, illegal}, 64'd1);
    chk("R6 result unchanged", {res_hi, res_lo}, held);
    @(negedge clk);
    chk("R6 illegal single cycle", {63'd0, illegal}, 64'd0);

    // R7: condition field 1111
    strobe(1'b1, enc_a(4'hF, 4'd3, 4'd2, 4'd4, 1'b0, 1'b0, 4'd1), 1'b1, 32'h3, 32'h3, 64'd5);
    chk("R7 never-condition no write", {62'd0, res_valid, illegal}, 64'd0);
    chk("R7 result unchanged", {res_hi, res_lo}, held);

    // R8: cond_pass low in both layouts
    strobe(1'b0, enc_c(4'd1, 4'd9, 4'd8, 1'b0, 1'b0, 4'd4), 1'b0, 32'h3, 32'h3, 64'd5);
    chk("R8 compact gated", {62'd0, res_valid, illegal}, 64'd0);
    strobe(1'b1, enc_a(4'h1, 4'd8, 4'd9, 4'd4, 1'b0, 1'b0, 4'd1), 1'b0, 32'h3, 32'h3, 64'd5);
    chk("R8 conditional gated", {62'd0, res_valid, illegal}, 64'd0);
    chk("R8 result unchanged", {res_hi, res_lo}, held);
    chk("R8 indices unchanged", {56'd0, wb_hi_idx, wb_lo_idx}, {56'd0, 4'd3, 4'd2});

    // R10: reset after activity
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears result", {res_hi, res_lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule